// File: doc/BRIEF.md
# Signed Residue Scaler

This block divides a signed number held in residue form by a scaling factor and returns the quotient, still in residue form. The factor is always a product of some of the base moduli, so only the division by that product is needed. The block first converts the operand into mixed-radix digits. The channel order used for the conversion depends on the selected factor. The digits below the factor are then dropped. The block reads the sign from the top digit and rebuilds the residues of the quotient for every modulus, including the moduli that were divided out.

Every modular operation is a subtract-and-multiply by a constant on a small residue channel. All constants are derived when the design is elaborated. These are the inverses used in the conversion for each ordering, the weights of the retained digits, and the offset used to correct negative operands. The datapath is pipelined. It takes one operand per clock, and each operand may choose a different factor.

Top module: `rns_scaler`

## Requirements
- R1: Residues travel on four 4-bit unsigned channels. Channel 0 carries the residue modulo 7, channel 1 modulo 11, channel 2 modulo 13 and channel 3 modulo 15, which gives a range M = 15015. A valid input residue is already reduced below its modulus. Channel c occupies bits 4c+3 down to 4c of the in_res and out_res buses.
- R2: The in_fsel input selects the divisor K. Value 0 selects 7, value 1 selects 11·13 = 143, value 2 selects 7·15 = 105 and value 3 selects 7·11·13 = 1001.
- R3: Let X in [0, M) be the number whose residues are presented. X is negative when its most significant mixed-radix digit is at least half of the last modulus in the conversion order, rounded up. For selects 0, 1 and 3 the last modulus is 15, so X is negative when X ≥ 8008. For select 2 the last modulus is 13, so X is negative when X ≥ 8085. out_negative reports this sign.
- R4: For a non-negative operand, out_res holds floor(X/K) reduced modulo each of the four moduli.
- R5: For a negative operand, the signed value is v = X − M. out_res holds floor(v/K), rounded toward minus infinity, reduced into [0, m) for each modulus m. This equals floor(X/K) − M/K.
- R6: An operand captured at a rising edge appears at the outputs after the fifth rising edge, counting the capturing edge. out_valid follows in_valid with this same delay.
- R7: A new operand may be accepted on every clock. Operands in adjacent cycles with different selects and signs give independent results.
- R8: While out_valid is low, out_res is all zero and out_negative is low.
- R9: While reset is active, and in the cycles that follow before any valid operand has crossed the pipeline, out_valid, out_res and out_negative are all zero.
- R10: Every residue reported with out_valid high is below its channel's modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fsel | input | 2 | Scaling factor select |
| in_res | input | 16 | Operand residues, four 4-bit channels |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 16 | Quotient residues, four 4-bit channels |
| out_negative | output | 1 | Operand was negative |

## Verification
In one clock the pipeline can hold operands that use different conversion orderings at different stages. In the same clock, the final stage may apply the negative-operand offset while the earlier stages run positive operands through another ordering. The bench provokes this with back-to-back operands whose select changes every cycle. Their values sit just either side of the sign threshold of each ordering, including the threshold of select 2, which differs from the others. A behavioural model computes each expected quotient by floor division of the signed value. The model is compared with the outputs on every clock, so a constant or sign applied to the wrong stage shows up as a residue mismatch in that exact cycle.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;

    localparam int NCH  = 4;
    localparam int RW   = 4;
    localparam int NSEL = 4;
    localparam int SW   = $clog2(NSEL);
    localparam int CW   = $clog2(NCH);
    localparam int LAT  = NCH + 1;

    typedef logic [NCH-1:0][RW-1:0] res_vec_t;

    typedef struct packed {
        logic           vld;
        logic [SW-1:0]  sel;
        res_vec_t       ch;
        res_vec_t       dig;
    } mrs_stage_t;

    typedef logic [NSEL-1:0][NCH-2:0][NCH-1:0][RW-1:0] inv_tab_t;
    typedef logic [NSEL-1:0][NCH-1:0][NCH-1:0][RW-1:0] wgt_tab_t;
    typedef logic [NSEL-1:0][NCH-1:0][RW-1:0]          off_tab_t;
    typedef logic [NSEL-1:0][RW-1:0]                   sel_tab_t;
    typedef logic [NSEL-1:0][NCH-1:0][CW-1:0]          ord_tab_t;

    function automatic int modulus(int c);
        case (c)
            0:       return 7;
            1:       return 11;
            2:       return 13;
            default: return 15;
        endcase
    endfunction

    // channel used at conversion position pos for select s
    function automatic int order_of(int s, int pos);
        int r;
        r = pos;
        case (s)
            1: case (pos) 0: r = 1; 1: r = 2; 2: r = 0; default: r = 3; endcase
            2: case (pos) 0: r = 0; 1: r = 3; 2: r = 1; default: r = 2; endcase
            default: r = pos;
        endcase
        return r;
    endfunction

    // number of leading moduli that form the divisor
    function automatic int prefix_len(int s);
        case (s)
            0:       return 1;
            3:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int mod_inv(int a, int m);
        int r;
        r = 0;
        for (int t = 1; t < m; t++)
            if (((a * t) % m) == 1) r = t;
        return r;
    endfunction

    function automatic ord_tab_t build_ord();
        ord_tab_t t;
        for (int s = 0; s < NSEL; s++)
            for (int p = 0; p < NCH; p++)
                t[s][p] = CW'(order_of(s, p));
        return t;
    endfunction

    function automatic inv_tab_t build_inv();
        inv_tab_t t;
        for (int s = 0; s < NSEL; s++)
            for (int st = 0; st < NCH - 1; st++)
                for (int c = 0; c < NCH; c++) begin
                    if (c == order_of(s, st))
                        t[s][st][c] = '0;
                    else
                        t[s][st][c] = RW'(mod_inv(modulus(order_of(s, st)) % modulus(c), modulus(c)));
                end
        return t;
    endfunction

    function automatic wgt_tab_t build_wgt();
        wgt_tab_t t;
        int w;
        for (int s = 0; s < NSEL; s++)
            for (int j = 0; j < NCH; j++)
                for (int c = 0; c < NCH; c++) begin
                    w = 0;
                    if (j >= prefix_len(s)) begin
                        w = 1;
                        for (int k = prefix_len(s); k < j; k++)
                            w = (w * modulus(order_of(s, k))) % modulus(c);
                    end
                    t[s][j][c] = RW'(w % modulus(c));
                end
        return t;
    endfunction

    // additive constant m - (M/K mod m) applied to negative operands
    function automatic off_tab_t build_off();
        off_tab_t t;
        int q;
        for (int s = 0; s < NSEL; s++)
            for (int c = 0; c < NCH; c++) begin
                q = 1;
                for (int k = prefix_len(s); k < NCH; k++)
                    q = q * modulus(order_of(s, k));
                t[s][c] = RW'((modulus(c) - (q % modulus(c))) % modulus(c));
            end
        return t;
    endfunction

    function automatic sel_tab_t build_last();
        sel_tab_t t;
        for (int s = 0; s < NSEL; s++)
            t[s] = RW'(modulus(order_of(s, NCH - 1)));
        return t;
    endfunction

    function automatic sel_tab_t build_thr();
        sel_tab_t t;
        for (int s = 0; s < NSEL; s++)
            t[s] = RW'((modulus(order_of(s, NCH - 1)) + 1) / 2);
        return t;
    endfunction

    localparam ord_tab_t ORD_TAB  = build_ord();
    localparam inv_tab_t INV_TAB  = build_inv();
    localparam wgt_tab_t WGT_TAB  = build_wgt();
    localparam off_tab_t OFF_TAB  = build_off();
    localparam sel_tab_t LAST_TAB = build_last();
    localparam sel_tab_t THR_TAB  = build_thr();

endpackage

// File: rtl/rns_mrs_step.sv
module rns_mrs_step
    import rns_scale_pkg::*;
#(
    parameter int STEP = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  mrs_stage_t in_st,
    output mrs_stage_t out_st
);

    mrs_stage_t     st_d, st_q;
    logic [RW-1:0]  pivot;
    int             diff;

    always_comb begin
        st_d  = in_st;
        pivot = in_st.ch[ORD_TAB[in_st.sel][STEP]];
        st_d.dig[STEP] = pivot;
        diff = 0;
        for (int c = 0; c < NCH; c++) begin
            diff = (int'(in_st.ch[c]) + modulus(c) - (int'(pivot) % modulus(c))) % modulus(c);
            st_d.ch[c] = RW'((diff * int'(INV_TAB[in_st.sel][STEP][c])) % modulus(c));
        end
        if (STEP == NCH - 2)
            st_d.dig[NCH-1] = st_d.ch[ORD_TAB[in_st.sel][NCH-1]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_st = st_q;

endmodule

// File: rtl/rns_scale_sum.sv
module rns_scale_sum
    import rns_scale_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [SW-1:0] in_sel,
    input  res_vec_t      in_dig,
    output logic          out_vld,
    output res_vec_t      out_res,
    output logic          out_neg
);

    typedef struct packed {
        logic     vld;
        logic     neg;
        res_vec_t res;
    } sum_t;

    sum_t sum_d, sum_q;
    logic neg;
    int   acc;

    always_comb begin
        sum_d = '0;
        neg   = in_dig[NCH-1] >= THR_TAB[in_sel];
        acc   = 0;
        if (in_vld) begin
            sum_d.vld = 1'b1;
            sum_d.neg = neg;
            for (int c = 0; c < NCH; c++) begin
                acc = neg ? int'(OFF_TAB[in_sel][c]) : 0;
                for (int j = 0; j < NCH; j++)
                    acc = acc + int'(in_dig[j]) * int'(WGT_TAB[in_sel][j][c]);
                sum_d.res[c] = RW'(acc % modulus(c));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign out_vld = sum_q.vld;
    assign out_neg = sum_q.neg;
    assign out_res = sum_q.res;

endmodule

// File: rtl/rns_scaler.sv
module rns_scaler
    import rns_scale_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SW-1:0]          in_fsel,
    input  logic [NCH*RW-1:0]      in_res,
    output logic                   out_valid,
    output logic [NCH*RW-1:0]      out_res,
    output logic                   out_negative
);

    mrs_stage_t cap_d, cap_q;
    mrs_stage_t pipe [NCH];
    res_vec_t   res_w;

    always_comb begin
        cap_d     = '0;
        cap_d.vld = in_valid;
        cap_d.sel = in_fsel;
        cap_d.ch  = res_vec_t'(in_res);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pipe[0] = cap_q;

    for (genvar s = 0; s < NCH - 1; s++) begin : g_step
        rns_mrs_step #(.STEP(s)) u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_st  (pipe[s]),
            .out_st (pipe[s+1])
        );
    end

    rns_scale_sum u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (pipe[NCH-1].vld),
        .in_sel  (pipe[NCH-1].sel),
        .in_dig  (pipe[NCH-1].dig),
        .out_vld (out_valid),
        .out_res (res_w),
        .out_neg (out_negative)
    );

    assign out_res = res_w;

endmodule

// File: rtl/rns_scaler_chk.sv
module rns_scaler_chk
    import rns_scale_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [NCH*RW-1:0]  out_res,
    input logic               out_negative,
    input mrs_stage_t         last_st
);

    logic [2:0] since_rst;
    res_vec_t   res_v;

    assign res_v = res_vec_t'(out_res);

    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
    end

    // R6: result valid follows operand valid by the pipeline depth
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R8: idle outputs stay quiet
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (res_v == '0 && !out_negative));

    // R3: the top digit feeding the sign decision lies below the last modulus
    p_top_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_st.vld |-> (last_st.dig[NCH-1] < LAST_TAB[last_st.sel]));

    // R3: channel reused as the last digit holds exactly that digit
    p_last_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_st.vld |-> (last_st.ch[ORD_TAB[last_st.sel][NCH-1]] == last_st.dig[NCH-1]));

    for (genvar c = 0; c < NCH; c++) begin : g_range
        localparam int MC = modulus(c);
        // R10: reported residues are reduced
        p_res_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(res_v[c]) < MC));
    end

endmodule

bind rns_scaler rns_scaler_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_res      (out_res),
    .out_negative (out_negative),
    .last_st      (pipe[3])
);

// File: tb/rns_scaler_tb.sv
module rns_scaler_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;
    localparam int BIG_M      = 15015;
    localparam int WATCHDOG   = 100000;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_fsel;
    logic [15:0] in_res;
    logic        out_valid;
    logic [15:0] out_res;
    logic        out_negative;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit vld;
        bit neg;
        int r [4];
    } exp_t;

    exp_t exp_q [$];

    rns_scaler u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_fsel      (in_fsel),
        .in_res       (in_res),
        .out_valid    (out_valid),
        .out_res      (out_res),
        .out_negative (out_negative)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int mod_of(int c);
        case (c) 0: return 7; 1: return 11; 2: return 13; default: return 15; endcase
    endfunction

    function automatic int div_of(int s);
        case (s) 0: return 7; 1: return 143; 2: return 105; default: return 1001; endcase
    endfunction

    function automatic int thr_of(int s);
        int pl;
        pl = (s == 2) ? 13 : 15;
        return ((pl + 1) / 2) * (BIG_M / pl);
    endfunction

    function automatic exp_t model(bit v, int s, int x);
        exp_t e;
        int val, k, y;
        e.vld = 0; e.neg = 0;
        for (int c = 0; c < 4; c++) e.r[c] = 0;
        if (v) begin
            k     = div_of(s);
            e.vld = 1;
            e.neg = (x >= thr_of(s));
            val   = e.neg ? x - BIG_M : x;
            y     = (val >= 0) ? val / k : -((-val + k - 1) / k);
            for (int c = 0; c < 4; c++)
                e.r[c] = ((y % mod_of(c)) + mod_of(c)) % mod_of(c);
        end
        return e;
    endfunction

    task automatic report(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, expv);
        end
    endtask

    task automatic compare();
        exp_t e;
        bit filling;
        int got;
        filling = (exp_q.size() < LAT);
        if (filling) e = model(0, 0, 0);
        else         e = exp_q.pop_front();
        report(out_valid == e.vld, filling ? "R9 out_valid" : "R6 out_valid",
               int'(out_valid), int'(e.vld));
        report(out_negative == e.neg, e.vld ? "R3 out_negative" : "R8 out_negative",
               int'(out_negative), int'(e.neg));
        for (int c = 0; c < 4; c++) begin
            got = int'(out_res[4*c +: 4]);
            if (!e.vld)
                report(got == e.r[c], filling ? "R9 idle residue" : "R8 idle residue", got, e.r[c]);
            else if (e.neg)
                report(got == e.r[c], "R5 negative quotient residue (R1 R2 R7)", got, e.r[c]);
            else
                report(got == e.r[c], "R4 quotient residue (R1 R2 R7)", got, e.r[c]);
            if (e.vld)
                report(got < mod_of(c), "R10 residue range", got, mod_of(c) - 1);
        end
    endtask

    task automatic drive(bit v, int s, int x);
        @(negedge clk);
        compare();
        in_valid = v;
        in_fsel  = 2'(s);
        for (int c = 0; c < 4; c++)
            in_res[4*c +: 4] = v ? 4'(x % mod_of(c)) : 4'($urandom_range(0, 14));
        exp_q.push_back(model(v, s, x));
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_fsel  = '0;
        in_res   = '0;
        repeat (3) @(negedge clk);
        // R9: outputs during reset
        report(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        report(out_res == '0, "R9 reset out_res", int'(out_res), 0);
        report(out_negative == 1'b0, "R9 reset out_negative", int'(out_negative), 0);
        rst_n = 1'b1;

        // directed corners, back to back, select rotating each cycle (R7)
        for (int s = 0; s < 4; s++) begin
            drive(1, s, 0);
            drive(1, s, 1);
            drive(1, s, div_of(s) - 1);
            drive(1, s, div_of(s));
            drive(1, s, thr_of(s) - 1);
            drive(1, s, thr_of(s));
            drive(1, s, thr_of(s) + 1);
            drive(1, s, BIG_M - 1);
            drive(1, s, BIG_M - 2);
            drive(1, s, BIG_M - div_of(s));
        end
        // select 2 threshold differs from the others (R3)
        drive(1, 2, 8008);
        drive(1, 0, 8084);
        drive(1, 2, 8084);
        drive(1, 3, 8085);
        drive(1, 2, 8085);
        drive(0, 0, 0);
        drive(1, 1, 14300);
        drive(0, 0, 0);
        drive(0, 0, 0);

        // streams mixing selects, signs and bubbles
        for (int i = 0; i < 4000; i++) begin
            int s, x;
            s = $urandom_range(0, 3);
            if ($urandom_range(0, 3) == 0)
                x = thr_of(s) + $urandom_range(0, 6) - 3;
            else
                x = $urandom_range(0, BIG_M - 1);
            drive($urandom_range(0, 4) != 0, s, x);
        end

        for (int i = 0; i < LAT + 3; i++) drive(0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual %0d cycles expected fewer than %0d", WATCHDOG, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule